// File: doc/BRIEF.md
# Duty-Cycled ADC Sampling Sequencer

This block drives an external two-channel analog-to-digital converter from a slow always-on clock. When it is enabled, it powers the converter up and waits a programmable settling time. It then converts channel 0 and channel 1 in that order. Each conversion is a select/valid handshake. A filter bank outside the block says, for each conversion, whether the result falls in the range it is watching. A pair of conversions counts as a match only when both channels match.

In low-power mode the sequencer powers the converter down between pairs and wakes after a programmed interval. After a programmed number of consecutive matching pairs, it stops powering down. It then samples back to back until a second, normal-power consecutive count is met. At that point it emits a one-cycle match event, captures both channel values, and counts again from zero. A pair that fails to match clears the counter of the current phase. In low-power mode a failed pair also returns the sequencer to the power-down/wake-up cycle. Without low-power mode, only the normal-power count is used.

Oneshot mode takes a single pair, ignores the filter, pulses a done flag and keeps the converter powered down until enable drops. Dropping enable, or asserting the soft reset, returns everything to its initial state.

Top module: `adc_seq`

## Requirements
- R1: While `enable` is low, `adc_pd` is 1 and `adc_sel` is 0 from the next clock edge on. When `enable` is high, `adc_pd` falls at the first clock edge.
- R2: While `soft_rst` is high, `adc_pd` is 1, `adc_sel` is 0, and the pair counters, phase and timers are cleared.
- R3: After `adc_pd` falls, `adc_sel` stays 0 for max(`settle_cyc`,1) cycles and then becomes 2'b01.
- R4: `adc_sel` is one-hot (2'b01 for channel 0, 2'b10 for channel 1) and is held until `adc_valid` is seen. Channel 0 always precedes channel 1. `adc_pd` is 0 while a channel is selected.
- R5: In low-power mode, before the low-power threshold is reached, each pair is followed by `adc_pd` high for max(`wake_cyc`,1) cycles, then a new settling period. A failed pair clears the low-power count.
- R6: A pair matches when `filt_match[0]` is 1 with the channel-0 `adc_valid` and `filt_match[1]` is 1 with the channel-1 `adc_valid`. After max(`lp_need`,1) consecutive matching pairs, the sequencer stays powered and goes straight on to channel 0.
- R7: In the normal-power phase, max(`np_need`,1) consecutive matching pairs cause `match_evt` to pulse for one cycle, in the cycle after the final valid, and the count restarts at zero. A failed pair clears the count and, in low-power mode, returns the sequencer to the low-power phase and sleep.
- R8: With `oneshot` set, exactly one pair is converted and `oneshot_done` pulses once. `match_evt` stays 0, and `adc_pd` stays 1 until `enable` drops.
- R9: `ch0_val`/`ch1_val` take `adc_data` in the cycle after the respective valid. `ch0_evt`/`ch1_evt` capture both values of the pair when `match_evt` or `oneshot_done` pulses.
- R10: Zero thresholds behave as one: `settle_cyc`=0 gives one settling cycle, `lp_need`=0 moves to normal power on the first matching pair, and `np_need`=0 gives an event on every matching normal-power pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the sequencer; low holds it in its initial state |
| soft_rst | input | 1 | Synchronous reset of the state machine, counters and timers |
| oneshot | input | 1 | Single-pair mode |
| lp_mode | input | 1 | Low-power phase with power-down between pairs |
| settle_cyc | input | 4 | Settling cycles after power-up |
| wake_cyc | input | 24 | Power-down interval between low-power pairs |
| lp_need | input | 8 | Consecutive matches needed in the low-power phase |
| np_need | input | 16 | Consecutive matches needed in the normal-power phase |
| adc_pd | output | 1 | Converter power-down |
| adc_sel | output | 2 | One-hot channel select, held until valid |
| adc_valid | input | 1 | Conversion result valid |
| adc_data | input | 10 | Conversion result |
| filt_match | input | 2 | Per-channel filter match, read with that channel's valid |
| ch0_val | output | 10 | Latest channel-0 result |
| ch1_val | output | 10 | Latest channel-1 result |
| ch0_evt | output | 10 | Channel-0 result at the last event |
| ch1_evt | output | 10 | Channel-1 result at the last event |
| match_evt | output | 1 | One-cycle debounce-complete pulse |
| oneshot_done | output | 1 | One-cycle oneshot-complete pulse |

## Verification
The checker relies on the converter side behaving well. It assumes `adc_valid` is raised only while a channel is selected, for a single cycle per conversion. It also assumes `oneshot` is not changed during a conversion pair. The bench's converter responder follows these rules: it waits a fixed latency after seeing a select, pulses valid once, and drops it when the select changes or clears. All configuration inputs change only while `enable` is low. The single exceptions are `enable` and `soft_rst`, which are deliberately dropped or raised mid-conversion.

// File: rtl/adc_seq.sv
module adc_seq #(
  parameter int DW = 10,
  parameter int SW = 4,
  parameter int WW = 24,
  parameter int LW = 8,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          soft_rst,
  input  logic          oneshot,
  input  logic          lp_mode,
  input  logic [SW-1:0] settle_cyc,
  input  logic [WW-1:0] wake_cyc,
  input  logic [LW-1:0] lp_need,
  input  logic [NW-1:0] np_need,
  output logic          adc_pd,
  output logic [1:0]    adc_sel,
  input  logic          adc_valid,
  input  logic [DW-1:0] adc_data,
  input  logic [1:0]    filt_match,
  output logic [DW-1:0] ch0_val,
  output logic [DW-1:0] ch1_val,
  output logic [DW-1:0] ch0_evt,
  output logic [DW-1:0] ch1_evt,
  output logic          match_evt,
  output logic          oneshot_done
);

  typedef enum logic [2:0] {S_IDLE, S_WARM, S_CH0, S_CH1, S_SLEEP, S_HALT} st_t;

  st_t st;
  logic [WW-1:0] tmr;
  logic [LW-1:0] lp_cnt;
  logic [NW-1:0] np_cnt;
  logic          np_ph;
  logic          m0;

  wire pair_ok   = m0 & filt_match[1];
  wire warm_done = ({1'b0, tmr} + (WW+1)'(1)) >= (WW+1)'(settle_cyc);
  wire wake_done = ({1'b0, tmr} + (WW+1)'(1)) >= {1'b0, wake_cyc};
  wire lp_hit    = ({1'b0, lp_cnt} + (LW+1)'(1)) >= {1'b0, lp_need};
  wire np_hit    = ({1'b0, np_cnt} + (NW+1)'(1)) >= {1'b0, np_need};

  assign adc_pd  = (st == S_IDLE) || (st == S_SLEEP) || (st == S_HALT);
  assign adc_sel = {st == S_CH1, st == S_CH0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      tmr          <= '0;
      lp_cnt       <= '0;
      np_cnt       <= '0;
      np_ph        <= 1'b0;
      m0           <= 1'b0;
      ch0_val      <= '0;
      ch1_val      <= '0;
      ch0_evt      <= '0;
      ch1_evt      <= '0;
      match_evt    <= 1'b0;
      oneshot_done <= 1'b0;
    end else if (!enable || soft_rst) begin
      st           <= S_IDLE;
      tmr          <= '0;
      lp_cnt       <= '0;
      np_cnt       <= '0;
      np_ph        <= 1'b0;
      m0           <= 1'b0;
      match_evt    <= 1'b0;
      oneshot_done <= 1'b0;
    end else begin
      match_evt    <= 1'b0;
      oneshot_done <= 1'b0;
      case (st)
        S_IDLE: begin
          st  <= S_WARM;
          tmr <= '0;
        end
        S_WARM: begin
          if (warm_done) st <= S_CH0;
          else           tmr <= tmr + 1'b1;
        end
        S_CH0: begin
          if (adc_valid) begin
            ch0_val <= adc_data;
            m0      <= filt_match[0];
            st      <= S_CH1;
          end
        end
        S_CH1: begin
          if (adc_valid) begin
            ch1_val <= adc_data;
            tmr     <= '0;
            if (oneshot) begin
              oneshot_done <= 1'b1;
              ch0_evt      <= ch0_val;
              ch1_evt      <= adc_data;
              st           <= S_HALT;
            end else if (lp_mode && !np_ph) begin
              if (pair_ok && lp_hit) begin
                lp_cnt <= '0;
                np_ph  <= 1'b1;
                st     <= S_CH0;
              end else begin
                lp_cnt <= pair_ok ? lp_cnt + 1'b1 : '0;
                st     <= S_SLEEP;
              end
            end else if (pair_ok) begin
              st <= S_CH0;
              if (np_hit) begin
                np_cnt    <= '0;
                match_evt <= 1'b1;
                ch0_evt   <= ch0_val;
                ch1_evt   <= adc_data;
              end else begin
                np_cnt <= np_cnt + 1'b1;
              end
            end else begin
              np_cnt <= '0;
              if (lp_mode) begin
                np_ph <= 1'b0;
                st    <= S_SLEEP;
              end else begin
                st <= S_CH0;
              end
            end
          end
        end
        S_SLEEP: begin
          if (wake_done) begin
            st  <= S_WARM;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_HALT:  st <= S_HALT;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       soft_rst,
  input logic       oneshot,
  input logic       adc_pd,
  input logic [1:0] adc_sel,
  input logic       adc_valid,
  input logic       match_evt,
  input logic       oneshot_done
);

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (adc_pd && adc_sel == 2'b00)); // R1

  AST_SOFT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (adc_pd && adc_sel == 2'b00 && !match_evt)); // R2

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(adc_sel)); // R4

  AST_SEL_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel != 2'b00) |-> !adc_pd); // R4

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel != 2'b00 && !adc_valid && enable && !soft_rst) |=> (adc_sel == $past(adc_sel))); // R4

  AST_CH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_sel == 2'b10 && $past(adc_sel) != 2'b10) |-> ($past(adc_sel) == 2'b01)); // R4

  AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> !match_evt); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    oneshot_done |=> !oneshot_done); // R8

  AST_ONESHOT_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |-> !$past(oneshot)); // R8

endmodule

bind adc_seq adc_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
  .oneshot(oneshot), .adc_pd(adc_pd), .adc_sel(adc_sel),
  .adc_valid(adc_valid), .match_evt(match_evt), .oneshot_done(oneshot_done)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, soft_rst = 1'b0, oneshot = 1'b0, lp_mode = 1'b0;
  logic [3:0]  settle_cyc = 4'd2;
  logic [23:0] wake_cyc = 24'd5;
  logic [7:0]  lp_need = 8'd2;
  logic [15:0] np_need = 16'd2;
  logic        adc_pd;
  logic [1:0]  adc_sel;
  logic        adc_valid = 1'b0;
  logic [9:0]  adc_data = '0;
  logic [1:0]  filt_match = 2'b00;
  logic [9:0]  ch0_val, ch1_val, ch0_evt, ch1_evt;
  logic        match_evt, oneshot_done;

  always #2 clk = ~clk;

  adc_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .oneshot(oneshot), .lp_mode(lp_mode), .settle_cyc(settle_cyc),
    .wake_cyc(wake_cyc), .lp_need(lp_need), .np_need(np_need),
    .adc_pd(adc_pd), .adc_sel(adc_sel), .adc_valid(adc_valid),
    .adc_data(adc_data), .filt_match(filt_match), .ch0_val(ch0_val),
    .ch1_val(ch1_val), .ch0_evt(ch0_evt), .ch1_evt(ch1_evt),
    .match_evt(match_evt), .oneshot_done(oneshot_done)
  );

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: phases 0 off, 1 settling, 2 chan0, 3 chan1, 4 asleep, 5 parked
  int ph, tcount, lpc, npc, m_np, m_m0, m_v0, m_v1, m_e0, m_e1, m_evt, m_done;

  function automatic int atleast1(input int x);
    return (x < 1) ? 1 : x;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= 0; tcount <= 0; lpc <= 0; npc <= 0; m_np <= 0; m_m0 <= 0;
      m_v0 <= 0; m_v1 <= 0; m_e0 <= 0; m_e1 <= 0; m_evt <= 0; m_done <= 0;
    end else if (!enable || soft_rst) begin
      ph <= 0; tcount <= 0; lpc <= 0; npc <= 0; m_np <= 0; m_m0 <= 0;
      m_evt <= 0; m_done <= 0;
    end else begin
      m_evt <= 0; m_done <= 0;
      if (ph == 0) begin
        ph <= 1; tcount <= 1;
      end else if (ph == 1) begin
        if (tcount >= atleast1(int'(settle_cyc))) ph <= 2;
        else tcount <= tcount + 1;
      end else if (ph == 2 && adc_valid) begin
        m_v0 <= int'(adc_data); m_m0 <= int'(filt_match[0]); ph <= 3;
      end else if (ph == 3 && adc_valid) begin
        m_v1 <= int'(adc_data);
        tcount <= 1;
        if (oneshot) begin
          m_done <= 1; m_e0 <= m_v0; m_e1 <= int'(adc_data); ph <= 5;
        end else if (lp_mode && m_np == 0) begin
          if (m_m0 == 1 && filt_match[1]) begin
            if (lpc + 1 == atleast1(int'(lp_need))) begin
              lpc <= 0; m_np <= 1; ph <= 2;
            end else begin
              lpc <= lpc + 1; ph <= 4;
            end
          end else begin
            lpc <= 0; ph <= 4;
          end
        end else if (m_m0 == 1 && filt_match[1]) begin
          ph <= 2;
          if (npc + 1 == atleast1(int'(np_need))) begin
            npc <= 0; m_evt <= 1; m_e0 <= m_v0; m_e1 <= int'(adc_data);
          end else npc <= npc + 1;
        end else begin
          npc <= 0;
          if (lp_mode) begin m_np <= 0; ph <= 4; end
          else ph <= 2;
        end
      end else if (ph == 4) begin
        if (tcount >= atleast1(int'(wake_cyc))) begin ph <= 1; tcount <= 1; end
        else tcount <= tcount + 1;
      end
    end
  end

  // Converter responder, observation counters and per-cycle comparison
  int lat = 1, wait_c = 0, dval = 5, miss_mod = 0;
  int pairs = 0, ev_cnt = 0, done_cnt = 0, sleeps = 0;
  int hi_run = 0, lo_run = 0, last_settle = 0, last_sleep = 0;
  logic prev_pd = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(adc_pd == (ph == 0 || ph == 4 || ph == 5), "R3 adc_pd", int'(adc_pd), int'(ph == 0 || ph == 4 || ph == 5));
      chk(adc_sel == ((ph == 2) ? 2'b01 : (ph == 3) ? 2'b10 : 2'b00), "R4 adc_sel", int'(adc_sel), ph);
      chk(int'(match_evt) == m_evt, "R7 match_evt", int'(match_evt), m_evt);
      chk(int'(oneshot_done) == m_done, "R8 oneshot_done", int'(oneshot_done), m_done);
      chk(int'(ch0_val) == m_v0 && int'(ch1_val) == m_v1, "R9 ch_val", int'({ch1_val, ch0_val}), (m_v1 << 10) | m_v0);
      chk(int'(ch0_evt) == m_e0 && int'(ch1_evt) == m_e1, "R9 ch_evt", int'({ch1_evt, ch0_evt}), (m_e1 << 10) | m_e0);
    end
    if (match_evt) ev_cnt++;
    if (oneshot_done) done_cnt++;
    if (adc_pd && !prev_pd && enable) sleeps++;
    prev_pd = adc_pd;
    if (adc_pd) hi_run++;
    else begin
      if (hi_run > 0) last_sleep = hi_run;
      hi_run = 0;
    end
    if (adc_pd) lo_run = 0;
    else if (adc_sel == 2'b00) lo_run++;
    else if (adc_sel == 2'b01 && lo_run > 0) begin last_settle = lo_run; lo_run = 0; end
    if (adc_sel != 2'b00 && !adc_valid) begin
      if (wait_c >= lat) begin
        adc_valid = 1'b1;
        dval = (dval + 37) % 1024;
        adc_data = 10'(dval);
        if (adc_sel == 2'b01) filt_match = 2'b01;
        else begin
          filt_match = (miss_mod != 0 && pairs % miss_mod == miss_mod - 1) ? 2'b00 : 2'b10;
          pairs++;
        end
        wait_c = 0;
      end else wait_c++;
    end else begin
      adc_valid = 1'b0;
      wait_c = 0;
    end
  end

  task automatic clr();
    @(posedge clk);
    pairs = 0; ev_cnt = 0; done_cnt = 0; sleeps = 0; lo_run = 0; last_settle = 0; last_sleep = 0;
  endtask

  task automatic wait_pairs(input int n);
    while (pairs < n) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic go_off();
    @(negedge clk) enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_pd == 1'b1 && adc_sel == 2'b00 && !match_evt, "R1 reset state", int'({adc_pd, adc_sel}), 4);

    // Normal power only, every pair matches
    lp_mode = 1'b0; np_need = 16'd3; miss_mod = 0;
    clr();
    @(negedge clk) enable = 1'b1;
    wait_pairs(7);
    chk(ev_cnt == 2, "R7 events after 7 pairs, need 3", ev_cnt, 2);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(adc_pd == 1'b1 && adc_sel == 2'b00, "R1 disable quiets converter", int'({adc_pd, adc_sel}), 4);
    go_off();

    // Low-power phase then normal power
    lp_mode = 1'b1; lp_need = 8'd2; np_need = 16'd2; settle_cyc = 4'd6; wake_cyc = 24'd5;
    clr();
    @(negedge clk) enable = 1'b1;
    wait_pairs(4);
    chk(ev_cnt == 1, "R7 one event after lp then np phase", ev_cnt, 1);
    chk(sleeps == 1, "R6 no power-down after lp threshold", sleeps, 1);
    chk(last_settle == 6, "R3 settling length", last_settle, 6);
    chk(last_sleep == 5, "R5 sleep length", last_sleep, 5);
    go_off();

    // Periodic misses on channel 1 only
    settle_cyc = 4'd2; miss_mod = 3;
    clr();
    @(negedge clk) enable = 1'b1;
    wait_pairs(9);
    chk(ev_cnt == 0, "R7 miss clears count and returns to lp", ev_cnt, 0);
    chk(sleeps == 6, "R5 sleeps with misses", sleeps, 6);
    go_off();

    // Oneshot
    miss_mod = 0; lp_mode = 1'b0; oneshot = 1'b1;
    clr();
    @(negedge clk) enable = 1'b1;
    repeat (60) @(posedge clk);
    chk(done_cnt == 1, "R8 single done pulse", done_cnt, 1);
    chk(pairs == 1, "R8 single pair converted", pairs, 1);
    chk(ev_cnt == 0, "R8 filter ignored", ev_cnt, 0);
    @(negedge clk);
    chk(adc_pd == 1'b1, "R8 stays powered down", int'(adc_pd), 1);
    go_off();
    oneshot = 1'b0;

    // Soft reset mid-run
    np_need = 16'd2;
    clr();
    @(negedge clk) enable = 1'b1;
    while (pairs < 1) @(posedge clk);
    @(negedge clk) soft_rst = 1'b1;
    @(negedge clk);
    chk(adc_pd == 1'b1 && adc_sel == 2'b00, "R2 soft reset quiets converter", int'({adc_pd, adc_sel}), 4);
    repeat (2) @(negedge clk);
    soft_rst = 1'b0;
    clr();
    wait_pairs(1);
    chk(ev_cnt == 0, "R2 soft reset clears pair count", ev_cnt, 0);
    go_off();

    // Zero thresholds
    lp_mode = 1'b1; lp_need = 8'd0; np_need = 16'd0; settle_cyc = 4'd0; wake_cyc = 24'd0;
    clr();
    @(negedge clk) enable = 1'b1;
    wait_pairs(3);
    chk(ev_cnt == 2, "R10 zero thresholds act as one", ev_cnt, 2);
    chk(sleeps == 0, "R10 no sleep with zero lp threshold", sleeps, 0);
    chk(last_settle == 1, "R10 zero settle gives one cycle", last_settle, 1);
    go_off();

    // Enable dropped while a channel is selected
    lp_mode = 1'b0; np_need = 16'd5; settle_cyc = 4'd1;
    clr();
    @(negedge clk) enable = 1'b1;
    while (pairs < 1) @(posedge clk);
    @(negedge clk) enable = 1'b0;
    @(negedge clk);
    chk(adc_pd == 1'b1 && adc_sel == 2'b00, "R1 disable mid-conversion", int'({adc_pd, adc_sel}), 4);
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule